// File: doc/BRIEF.md
# Offset Thermal Trip Controller

This block decides when a thermal throttling event is in force. A configuration register holds two fields: a maximum junction temperature and an offset in degrees Celsius. The trip threshold is the maximum minus the offset, and it saturates at zero instead of wrapping. Each cycle with a valid temperature sample, the sample is compared against this threshold. A sample at or above the threshold starts an event, and `throttle_active` tells the operating-point logic to reduce frequency and voltage.

If the event is still active a fixed number of cycles after it began, the block escalates and raises `clkmod_req` to ask for clock modulation. The event ends, and both outputs drop together, only after two consecutive valid samples fall strictly below the threshold. This avoids chatter at the trip point. With the offset at its reset value of zero, the block trips at the maximum temperature itself.

The controller is a three-state machine:

- **NORMAL**: no event is active.
- **THROTTLE**: the event is active and operating-point reduction is in progress.
- **MODULATE**: the event has escalated to a clock-modulation request.

Its transitions are:

- **trip**: NORMAL to THROTTLE, on a valid sample at or above the threshold.
- **escalate**: THROTTLE to MODULATE, when the escalation timer expires.
- **recover**: THROTTLE or MODULATE to NORMAL, on the second consecutive valid sample below the threshold.

Top module: `thermtrip_ctrl`

## Requirements
- R1: After reset, `cfg_rd_data` reads `TJMAX_RST << 16` (offset 0), and both `throttle_active` and `clkmod_req` are low.
- R2: A write stores only bits [29:16] of `cfg_wr_data`. Bits [29:24] are the offset and bits [23:16] are the maximum temperature. All other bits read back as zero, and the new value is visible on `cfg_rd_data` the cycle after the write.
- R3: The threshold is maximum minus offset. A valid sample with `temp_in` at or above the threshold raises `throttle_active` from the next cycle. The threshold used is the register content in the sample's cycle.
- R4: When the offset exceeds the maximum field, the threshold is 0, so any valid sample (including temperature 0) trips the event.
- R5: Cycles with `temp_valid` low never start or end an event.
- R6: An event ends only on the second of two consecutive valid samples strictly below the threshold. A valid sample at or above the threshold between them restarts the count. Cycles without a valid sample do not break the count.
- R7: If the event persists, `clkmod_req` rises exactly `TIMEOUT` cycles after `throttle_active` rises. It stays high until the event ends, and then falls in the same cycle as `throttle_active`.
- R8: When the recover condition and the timer expiry fall on the same cycle, the event ends and `clkmod_req` stays low.
- R9: `clkmod_req` is never high while `throttle_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_data | output | 32 | Configuration register read-back |
| temp_valid | input | 1 | Temperature sample valid |
| temp_in | input | 8 | Temperature sample in degrees Celsius |
| throttle_active | output | 1 | Thermal event in force |
| clkmod_req | output | 1 | Clock-modulation escalation request |

## Verification
Recovery and escalation can land on the same clock edge: the second below-threshold sample arrives exactly when the escalation timer reaches its limit. The bench provokes this directly. It trips an event, idles for `TIMEOUT-2` cycles, and then supplies two below-threshold samples, so that the second one meets the expiry. It then expects `throttle_active` to fall with `clkmod_req` never rising. Random runs with temperatures hovering around the threshold reach the same collision, and a bench reference model judges each cycle.

// File: rtl/thermtrip_pkg.sv
package thermtrip_pkg;
    localparam int TEMP_W  = 8;
    localparam int OFF_W   = 6;
    localparam int TJ_LSB  = 16;
    localparam int OFF_LSB = 24;
    localparam logic [31:0] CFG_MASK = 32'h3FFF_0000;

    typedef enum logic [1:0] {
        ST_NORMAL   = 2'd0,
        ST_THROTTLE = 2'd1,
        ST_MODULATE = 2'd2
    } trip_state_e;
endpackage

// File: rtl/thermtrip_cfg.sv
module thermtrip_cfg
    import thermtrip_pkg::*;
#(
    parameter int TJMAX_RST = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic [TEMP_W-1:0] threshold
);
    logic [TEMP_W-1:0] tj_q;
    logic [OFF_W-1:0]  off_q;
    logic [TEMP_W-1:0] off_ext;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tj_q  <= TEMP_W'(TJMAX_RST);
            off_q <= '0;
        end else if (wr_en) begin
            tj_q  <= wr_data[TJ_LSB +: TEMP_W];
            off_q <= wr_data[OFF_LSB +: OFF_W];
        end
    end

    always_comb begin
        off_ext   = {{(TEMP_W-OFF_W){1'b0}}, off_q};
        threshold = (off_ext > tj_q) ? '0 : (tj_q - off_ext);
        rd_data   = '0;
        rd_data[TJ_LSB +: TEMP_W] = tj_q;
        rd_data[OFF_LSB +: OFF_W] = off_q;
    end

    // R2
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == ($past(wr_data) & CFG_MASK));
endmodule

// File: rtl/thermtrip_fsm.sv
module thermtrip_fsm
    import thermtrip_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              temp_valid,
    input  logic [TEMP_W-1:0] temp_in,
    input  logic [TEMP_W-1:0] threshold,
    output logic              throttle_active,
    output logic              clkmod_req
);
    localparam int TIMER_W = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT);

    trip_state_e       state_q, state_d;
    logic [TIMER_W-1:0] timer_q;
    logic              below_q;
    logic              hot, cool_done, expired;

    assign hot       = temp_in >= threshold;
    assign cool_done = temp_valid && !hot && below_q;
    assign expired   = timer_q == TIMER_W'(TIMEOUT - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL:   if (temp_valid && hot) state_d = ST_THROTTLE;
            ST_THROTTLE: if (cool_done)         state_d = ST_NORMAL;
                         else if (expired)      state_d = ST_MODULATE;
            ST_MODULATE: if (cool_done)         state_d = ST_NORMAL;
            default:                            state_d = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= '0;
            below_q <= 1'b0;
        end else begin
            if (state_q == ST_THROTTLE && state_d == ST_THROTTLE)
                timer_q <= timer_q + TIMER_W'(1);
            else
                timer_q <= '0;
            if (state_d == ST_NORMAL) below_q <= 1'b0;
            else if (temp_valid)      below_q <= !hot;
        end
    end

    always_comb begin
        throttle_active = state_q != ST_NORMAL;
        clkmod_req      = state_q == ST_MODULATE;
    end

    // R3
    trip_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL && temp_valid && temp_in >= threshold) |=> throttle_active);
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!temp_valid && state_q != ST_THROTTLE) |=> $stable(state_q));
    // R6
    recover_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(throttle_active) |-> $past(temp_valid && below_q && temp_in < threshold));
    // R7
    escalate_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clkmod_req) |-> $past(state_q == ST_THROTTLE && expired));
    // R9
    mod_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clkmod_req |-> throttle_active);
endmodule

// File: rtl/thermtrip_ctrl.sv
module thermtrip_ctrl
    import thermtrip_pkg::*;
#(
    parameter int TJMAX_RST = 100,
    parameter int TIMEOUT   = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [31:0] cfg_wr_data,
    output logic [31:0] cfg_rd_data,
    input  logic        temp_valid,
    input  logic [7:0]  temp_in,
    output logic        throttle_active,
    output logic        clkmod_req
);
    logic [TEMP_W-1:0] threshold;

    thermtrip_cfg #(.TJMAX_RST(TJMAX_RST)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_data   (cfg_wr_data),
        .rd_data   (cfg_rd_data),
        .threshold (threshold)
    );

    thermtrip_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .temp_valid      (temp_valid),
        .temp_in         (temp_in),
        .threshold       (threshold),
        .throttle_active (throttle_active),
        .clkmod_req      (clkmod_req)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!throttle_active && !clkmod_req));
endmodule

// File: tb/sim_thermtrip_ctrl.sv
`timescale 1ns/1ps
module sim_thermtrip_ctrl;
    localparam int TO = 16;
    localparam int TJR = 100;
    localparam logic [31:0] MASK = 32'h3FFF_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic temp_valid = 1'b0;
    logic [7:0] temp_in = '0;
    logic throttle_active, clkmod_req;

    int checks = 0;
    int fails = 0;
    logic [31:0] m_reg;
    int m_st, m_timer;
    logic m_below;

    always #2 clk = ~clk;

    thermtrip_ctrl #(.TJMAX_RST(TJR), .TIMEOUT(TO)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .temp_valid(temp_valid), .temp_in(temp_in),
        .throttle_active(throttle_active), .clkmod_req(clkmod_req)
    );

    function automatic int thr_of(input logic [31:0] r);
        int tj = int'(r[23:16]);
        int off = int'(r[29:24]);
        return (off > tj) ? 0 : tj - off;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic we, input logic [31:0] wd, input logic tv, input logic [7:0] t);
        logic hot, below_now, cool;
        int ns;
        hot = tv && (int'(t) >= thr_of(m_reg));
        below_now = tv && (int'(t) < thr_of(m_reg));
        cool = below_now && m_below;
        ns = m_st;
        if (m_st == 0) begin
            if (hot) ns = 1;
        end else if (m_st == 1) begin
            if (cool) ns = 0;
            else if (m_timer == TO - 1) ns = 2;
        end else begin
            if (cool) ns = 0;
        end
        m_timer = (m_st == 1 && ns == 1) ? m_timer + 1 : 0;
        if (ns == 0) m_below = 1'b0;
        else if (tv) m_below = below_now;
        m_st = ns;
        if (we) m_reg = wd & MASK;
    endtask

    task automatic cyc(input logic we, input logic [31:0] wd, input logic tv, input logic [7:0] t);
        @(negedge clk);
        cfg_wr_en = we; cfg_wr_data = wd; temp_valid = tv; temp_in = t;
        model_step(we, wd, tv, t);
        @(posedge clk);
        #1;
        check("R3,R6 throttle_active", {31'b0, throttle_active}, {31'b0, m_st != 0});
        check("R7 clkmod_req", {31'b0, clkmod_req}, {31'b0, m_st == 2});
        check("R2 cfg_rd_data", cfg_rd_data, m_reg);
    endtask

    function automatic logic [31:0] mk(input int tj, input int off);
        return {2'b00, 6'(off), 8'(tj), 16'h0};
    endfunction

    initial begin : wdog
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(32'd2718);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_reg = 32'(TJR) << 16; m_st = 0; m_timer = 0; m_below = 1'b0;
        #1;
        // R1 reset state
        check("R1 reset rd_data", cfg_rd_data, 32'(TJR) << 16);
        check("R1 reset throttle", {31'b0, throttle_active}, 32'd0);
        check("R1 reset clkmod", {31'b0, clkmod_req}, 32'd0);

        // R2 masked write
        cyc(1'b1, 32'hFFFF_FFFF, 1'b0, 8'd0);
        check("R2 masked readback", cfg_rd_data, 32'h3FFF_0000);

        // R5 hot temperature without valid is ignored
        cyc(1'b1, mk(90, 10), 1'b0, 8'd0);
        cyc(1'b0, 0, 1'b0, 8'd250);
        cyc(1'b0, 0, 1'b0, 8'd250);
        check("R5 invalid sample ignored", {31'b0, throttle_active}, 32'd0);

        // R3 threshold 80
        cyc(1'b0, 0, 1'b1, 8'd79);
        check("R3 below threshold no trip", {31'b0, throttle_active}, 32'd0);
        cyc(1'b0, 0, 1'b1, 8'd80);
        check("R3 trip at threshold", {31'b0, throttle_active}, 32'd1);

        // R6 hysteresis
        cyc(1'b0, 0, 1'b1, 8'd79);
        check("R6 one below keeps event", {31'b0, throttle_active}, 32'd1);
        cyc(1'b0, 0, 1'b1, 8'd80);
        cyc(1'b0, 0, 1'b1, 8'd70);
        cyc(1'b0, 0, 1'b0, 8'd0);
        check("R6 count restarted", {31'b0, throttle_active}, 32'd1);
        cyc(1'b0, 0, 1'b1, 8'd70);
        check("R6 two below ends event", {31'b0, throttle_active}, 32'd0);

        // R7 exact escalation delay
        cyc(1'b0, 0, 1'b1, 8'd95);
        for (int i = 0; i < TO - 1; i++) cyc(1'b0, 0, 1'b1, 8'd95);
        check("R7 no request before timeout", {31'b0, clkmod_req}, 32'd0);
        cyc(1'b0, 0, 1'b1, 8'd95);
        check("R7 request at timeout", {31'b0, clkmod_req}, 32'd1);
        cyc(1'b0, 0, 1'b1, 8'd10);
        cyc(1'b0, 0, 1'b1, 8'd10);
        check("R7 request drops with event", {31'b0, clkmod_req}, 32'd0);
        check("R9 event over", {31'b0, throttle_active}, 32'd0);

        // R8 recovery coincides with timer expiry
        cyc(1'b0, 0, 1'b1, 8'd85);
        for (int i = 0; i < TO - 2; i++) cyc(1'b0, 0, 1'b0, 8'd0);
        cyc(1'b0, 0, 1'b1, 8'd5);
        cyc(1'b0, 0, 1'b1, 8'd5);
        check("R8 recover wins throttle", {31'b0, throttle_active}, 32'd0);
        check("R8 recover wins clkmod", {31'b0, clkmod_req}, 32'd0);
        cyc(1'b0, 0, 1'b0, 8'd0);
        check("R8 clkmod stays low", {31'b0, clkmod_req}, 32'd0);

        // R4 saturation: 20 - 40 would wrap to 236
        cyc(1'b1, mk(20, 40), 1'b0, 8'd0);
        cyc(1'b0, 0, 1'b1, 8'd0);
        check("R4 saturated threshold trips at 0", {31'b0, throttle_active}, 32'd1);
        cyc(1'b1, mk(100, 0), 1'b0, 8'd0);
        cyc(1'b0, 0, 1'b1, 8'd99);
        cyc(1'b0, 0, 1'b1, 8'd99);
        check("R4 clear after reprogram", {31'b0, throttle_active}, 32'd0);

        // random mix checked by model
        for (int n = 0; n < 4000; n++) begin
            logic we, tv;
            logic [31:0] wd;
            int th, t;
            we = ($urandom % 50) == 0;
            wd = mk(40 + ($urandom % 90), $urandom % 64);
            if (($urandom % 4) == 0) wd = $urandom;
            tv = ($urandom % 3) != 0;
            th = thr_of(m_reg);
            t = th + int'($urandom % 9) - 4;
            if (t < 0) t = 0;
            if (t > 255) t = 255;
            cyc(we, wd, tv, 8'(t));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule